// File: doc/BRIEF.md
# Mirrored-Plane Path Selector

This block sits in the control path of an optical switching fabric made of two planes with the same topology, both built from 2x2 switch elements. In the first plane an element loses power when it is set to bar and is nearly lossless when set to cross. The second plane is mirrored, so the loss class of each setting is swapped: bar is nearly lossless and cross is lossy. A path is computed elsewhere. For that path, the block receives the bar/cross setting of every element it traverses, one bit per element.

For each accepted path the block counts the elements set to bar. That count is the lossy-element count on the first plane, and the count of cross settings is the lossy count on the mirrored plane. The block routes the connection on the plane with the smaller count. It then adds the fixed penalty of the input plane selector, compares the total against a limit sampled with the path, and marks the connection blocked if the total is over that limit. Results are held in one output register that has its own valid/ready handshake.

Top module: `mirror_path_sel`

## Requirements
- R1: Element setting encoding is bit i of `path_i` = 1 for bar and 0 for cross. When 2·X < NUM_STAGES, where X is the number of 1 bits, `plane_o` is 0 (normal plane) and `penalty_o` is X + SEL_PENALTY.
- R2: When 2·X > NUM_STAGES, `plane_o` is 1 (mirrored plane) and `penalty_o` is NUM_STAGES − X + SEL_PENALTY.
- R3: When 2·X equals NUM_STAGES, which is only possible for an even stage count, `plane_o` is 0 and `penalty_o` is X + SEL_PENALTY.
- R4: `penalty_o` always lies between SEL_PENALTY and floor(NUM_STAGES/2) + SEL_PENALTY, inclusive.
- R5: `blocked_o` is 1 exactly when `penalty_o` is greater than the limit that was sampled with the path. A penalty equal to the limit is not blocked.
- R6: A path is accepted on a clock edge where `valid_i` and `ready_o` are both 1. Its results appear with `res_valid_o` = 1 right after that edge. `res_valid_o` drops after an edge where `res_ready_i` = 1 and no new path is accepted.
- R7: While `res_valid_o` = 1 and `res_ready_i` = 0, `ready_o` is 0, the results stay unchanged, and any path offered on `valid_i` is not taken.
- R8: After reset, `res_valid_o`, `plane_o`, `penalty_o` and `blocked_o` are 0 and `ready_o` is 1.
- R9: Changes on `limit_i` after a path has been accepted do not affect that path's `blocked_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A path setting vector is offered |
| ready_o | output | 1 | The block can take a path this cycle |
| path_i | input | NUM_STAGES | Per-element setting, 1 = bar, 0 = cross |
| limit_i | input | PEN_W | Largest penalty allowed for this path |
| res_valid_o | output | 1 | The result register holds a result |
| res_ready_i | input | 1 | The consumer takes the result |
| plane_o | output | 1 | 0 = normal plane, 1 = mirrored plane |
| penalty_o | output | PEN_W | Lossy elements on the chosen plane plus the selector penalty |
| blocked_o | output | 1 | The penalty is over the limit |

## Verification
The assertions assume two things about the inputs. First, `path_i` and `limit_i` are stable and known whenever `valid_i` is high. Second, the consumer may hold `res_ready_i` low for any number of cycles. The bench changes inputs only on the falling clock edge. It keeps `valid_i` high through a stall until the path is taken, and it changes `limit_i` only while a result is waiting, which exercises R9. The tie rule of R3 is only reachable with an even stage count, so a second instance with six stages covers it.

// File: rtl/mirsel_pkg.sv
package mirsel_pkg;
  typedef enum logic {
    PLANE_NORMAL = 1'b0,
    PLANE_MIRROR = 1'b1
  } plane_e;
endpackage

// File: rtl/bar_counter.sv
module bar_counter #(
  parameter int NUM_STAGES = 7,
  localparam int CNT_W = $clog2(NUM_STAGES + 1)
) (
  input  logic [NUM_STAGES-1:0] path_i,
  output logic [CNT_W-1:0]      bars_o
);
  // ripple chain of partial sums, one adder per element
  logic [CNT_W-1:0] part [NUM_STAGES+1];
  assign part[0] = '0;
  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_sum
    assign part[g+1] = part[g] + CNT_W'(path_i[g]);
  end
  assign bars_o = part[NUM_STAGES];
endmodule

// File: rtl/plane_picker.sv
module plane_picker
  import mirsel_pkg::*;
#(
  parameter int NUM_STAGES  = 7,
  parameter int SEL_PENALTY = 1,
  localparam int CNT_W = $clog2(NUM_STAGES + 1),
  localparam int PEN_W = $clog2(NUM_STAGES / 2 + SEL_PENALTY + 1)
) (
  input  logic [CNT_W-1:0] bars_i,
  output plane_e           plane_o,
  output logic [PEN_W-1:0] penalty_o
);
  localparam logic [CNT_W:0]   STAGES_X = (CNT_W + 1)'(NUM_STAGES);
  localparam logic [CNT_W-1:0] STAGES_C = CNT_W'(NUM_STAGES);
  localparam logic [PEN_W-1:0] SEL_P    = PEN_W'(SEL_PENALTY);

  logic             go_mirror;
  logic [CNT_W-1:0] lossy;

  // strictly more than half bars -> mirrored plane; tie stays normal
  assign go_mirror = {bars_i, 1'b0} > STAGES_X;
  assign lossy     = go_mirror ? (STAGES_C - bars_i) : bars_i;
  assign plane_o   = go_mirror ? PLANE_MIRROR : PLANE_NORMAL;
  assign penalty_o = PEN_W'(lossy) + SEL_P;
endmodule

// File: rtl/limit_check.sv
module limit_check #(
  parameter int PEN_W = 3
) (
  input  logic [PEN_W-1:0] penalty_i,
  input  logic [PEN_W-1:0] limit_i,
  output logic             blocked_o
);
  assign blocked_o = penalty_i > limit_i;
endmodule

// File: rtl/mirror_path_sel.sv
module mirror_path_sel
  import mirsel_pkg::*;
#(
  parameter int NUM_STAGES  = 7,
  parameter int SEL_PENALTY = 1,
  localparam int CNT_W = $clog2(NUM_STAGES + 1),
  localparam int PEN_W = $clog2(NUM_STAGES / 2 + SEL_PENALTY + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  output logic                  ready_o,
  input  logic [NUM_STAGES-1:0] path_i,
  input  logic [PEN_W-1:0]      limit_i,
  output logic                  res_valid_o,
  input  logic                  res_ready_i,
  output logic                  plane_o,
  output logic [PEN_W-1:0]      penalty_o,
  output logic                  blocked_o
);
  logic [CNT_W-1:0] bars;
  plane_e           plane_nxt;
  logic [PEN_W-1:0] pen_nxt;
  logic             blk_nxt;
  logic             take;

  logic             out_v_q;
  plane_e           plane_q;
  logic [PEN_W-1:0] pen_q;
  logic             blk_q;

  bar_counter #(.NUM_STAGES(NUM_STAGES)) u_cnt (
    .path_i (path_i),
    .bars_o (bars)
  );

  plane_picker #(.NUM_STAGES(NUM_STAGES), .SEL_PENALTY(SEL_PENALTY)) u_pick (
    .bars_i    (bars),
    .plane_o   (plane_nxt),
    .penalty_o (pen_nxt)
  );

  limit_check #(.PEN_W(PEN_W)) u_lim (
    .penalty_i (pen_nxt),
    .limit_i   (limit_i),
    .blocked_o (blk_nxt)
  );

  assign ready_o = !out_v_q || res_ready_i;
  assign take    = valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_v_q <= 1'b0;
      plane_q <= PLANE_NORMAL;
      pen_q   <= '0;
      blk_q   <= 1'b0;
    end else if (take) begin
      out_v_q <= 1'b1;
      plane_q <= plane_nxt;
      pen_q   <= pen_nxt;
      blk_q   <= blk_nxt;
    end else if (res_ready_i) begin
      out_v_q <= 1'b0;
    end
  end

  assign res_valid_o = out_v_q;
  assign plane_o     = plane_q;
  assign penalty_o   = pen_q;
  assign blocked_o   = blk_q;
endmodule

// File: rtl/mirror_path_sel_chk.sv
module mirror_path_sel_chk #(
  parameter int NUM_STAGES  = 7,
  parameter int SEL_PENALTY = 1,
  parameter int PEN_W       = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  valid_i,
  input logic                  ready_o,
  input logic [NUM_STAGES-1:0] path_i,
  input logic [PEN_W-1:0]      limit_i,
  input logic                  res_valid_o,
  input logic                  res_ready_i,
  input logic                  plane_o,
  input logic [PEN_W-1:0]      penalty_o,
  input logic                  blocked_o
);
  localparam int PEN_MAX = NUM_STAGES / 2 + SEL_PENALTY;

  logic fire;
  assign fire = valid_i && ready_o;

  a_r6_result_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> res_valid_o);

  a_r7_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=>
      (res_valid_o && $stable(plane_o) && $stable(penalty_o) && $stable(blocked_o)));

  a_r7_no_ready_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |-> !ready_o);

  a_r4_penalty_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (int'(penalty_o) >= SEL_PENALTY && int'(penalty_o) <= PEN_MAX));

  a_r2_mirror_on_majority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && ($countones(path_i) * 2 > NUM_STAGES)) |=> plane_o);

  a_r1_normal_on_minority_or_tie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && ($countones(path_i) * 2 <= NUM_STAGES)) |=> !plane_o);

  a_r5_block_vs_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (blocked_o == (penalty_o > $past(limit_i))));

  a_r8_idle_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> ready_o);
endmodule

bind mirror_path_sel mirror_path_sel_chk #(
  .NUM_STAGES (NUM_STAGES),
  .SEL_PENALTY(SEL_PENALTY),
  .PEN_W      (PEN_W)
) u_chk (.*);

// File: tb/tb_mirror_path_sel.sv
module tb_mirror_path_sel;
  localparam int CLK_PERIOD = 10;
  localparam int S   = 7;
  localparam int SE  = 6;
  localparam int SP  = 1;
  localparam int PW  = $clog2(S / 2 + SP + 1);
  localparam int PWE = $clog2(SE / 2 + SP + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          valid, ready, res_valid, res_ready, plane, blocked;
  logic [S-1:0]  path;
  logic [PW-1:0] limit, penalty;

  logic           e_valid, e_ready, e_res_valid, e_plane, e_blocked;
  logic [SE-1:0]  e_path;
  logic [PWE-1:0] e_limit, e_penalty;

  int checks = 0;
  int fails  = 0;

  mirror_path_sel #(.NUM_STAGES(S), .SEL_PENALTY(SP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .ready_o(ready),
    .path_i(path), .limit_i(limit), .res_valid_o(res_valid),
    .res_ready_i(res_ready), .plane_o(plane), .penalty_o(penalty),
    .blocked_o(blocked));

  mirror_path_sel #(.NUM_STAGES(SE), .SEL_PENALTY(SP)) dut_even (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(e_valid), .ready_o(e_ready),
    .path_i(e_path), .limit_i(e_limit), .res_valid_o(e_res_valid),
    .res_ready_i(1'b1), .plane_o(e_plane), .penalty_o(e_penalty),
    .blocked_o(e_blocked));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int bars_of(input int v, input int n);
    int c = 0;
    for (int i = 0; i < n; i++) c += (v >> i) & 1;
    return c;
  endfunction

  // offer one path on the 7-stage instance, check its registered result
  task automatic send_check(input int p, input int lim, input string req);
    int x, ep, el;
    x  = bars_of(p, S);
    ep = (2 * x > S) ? 1 : 0;
    el = ep ? (S - x + SP) : (x + SP);
    @(negedge clk);
    check({req, " ready"}, int'(ready), 1);
    valid = 1'b1; path = S'(p); limit = PW'(lim);
    @(negedge clk);
    valid = 1'b0;
    check({req, " valid"}, int'(res_valid), 1);
    check({req, " plane"}, int'(plane), ep);
    check({req, " penalty"}, int'(penalty), el);
    check({req, " blocked R5"}, int'(blocked), (el > lim) ? 1 : 0);
  endtask

  task automatic test_reset();
    check("R8 res_valid", int'(res_valid), 0);
    check("R8 ready", int'(ready), 1);
    check("R8 plane", int'(plane), 0);
    check("R8 penalty", int'(penalty), 0);
    check("R8 blocked", int'(blocked), 0);
  endtask

  task automatic test_basic();
    send_check(7'b0000000, 7, "R1 all cross");
    send_check(7'b1111111, 7, "R2 all bar");
    send_check(7'b0000101, 7, "R1 two bars");
    send_check(7'b1110110, 7, "R2 five bars");
    send_check(7'b0010011, 7, "R1 three bars edge");
    send_check(7'b1011010, 7, "R2 four bars edge");
  endtask

  task automatic test_limit();
    send_check(7'b0101010, 4, "R5 equal limit");
    check("R5 equal not blocked", int'(blocked), 0);
    send_check(7'b0101010, 3, "R5 below limit");
    check("R5 over limit blocked", int'(blocked), 1);
    send_check(7'b1111111, 0, "R5 zero limit");
  endtask

  task automatic test_sweep();
    for (int p = 0; p < (1 << S); p++) begin
      send_check(p, 3, (2 * bars_of(p, S) > S) ? "R2 sweep" : "R1 sweep");
      check("R4 penalty bound", (int'(penalty) <= S / 2 + SP && int'(penalty) >= SP) ? 1 : 0, 1);
    end
  endtask

  task automatic test_stall();
    @(negedge clk);
    res_ready = 1'b0;
    valid = 1'b1; path = 7'b0000111; limit = PW'(7);
    @(negedge clk);
    check("R6 stalled accept valid", int'(res_valid), 1);
    check("R1 stalled penalty", int'(penalty), 4);
    check("R7 ready low", int'(ready), 0);
    path = 7'b1111110; limit = '0;  // offered but must not be taken
    @(negedge clk);
    check("R7 held penalty", int'(penalty), 4);
    check("R7 held plane", int'(plane), 0);
    check("R9 limit change ignored", int'(blocked), 0);
    check("R7 still ready low", int'(ready), 0);
    res_ready = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    check("R7 new path after release plane", int'(plane), 1);
    check("R7 new path penalty", int'(penalty), 2);
    check("R5 new path blocked", int'(blocked), 1);
    @(negedge clk);
    check("R6 valid drops", int'(res_valid), 0);
    check("R6 ready back", int'(ready), 1);
  endtask

  task automatic send_even(input int p, input int ep, input int el, input string req);
    @(negedge clk);
    e_valid = 1'b1; e_path = SE'(p); e_limit = PWE'(7);
    @(negedge clk);
    e_valid = 1'b0;
    check({req, " plane"}, int'(e_plane), ep);
    check({req, " penalty"}, int'(e_penalty), el);
  endtask

  task automatic test_tie();
    send_even(6'b000111, 0, 4, "R3 tie");
    send_even(6'b101010, 0, 4, "R3 tie alt");
    send_even(6'b011011, 1, 3, "R2 even majority");
    send_even(6'b000011, 0, 3, "R1 even minority");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    valid = 1'b0; path = '0; limit = '0; res_ready = 1'b1;
    e_valid = 1'b0; e_path = '0; e_limit = '0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_basic();
    test_limit();
    test_stall();
    test_tie();
    test_sweep();
    summary();
    $finish;
  end
endmodule